// File: doc/BRIEF.md
# SPI Master End-of-Frame Timing Controller

This block sits between an SPI master shift engine and the chip-select and enable pins. When the shift engine reports the last bit of a character, the controller keeps chip select asserted for a programmable number of system-clock cycles. This gives the slave a hold time. The controller then releases chip select and starts a watchdog. The watchdog counts SPI bit-clock ticks while the slave is expected to raise its enable handshake line to acknowledge the character. If the watchdog expires first, a sticky desynchronization flag is set.

The hold delay and the watchdog run in sequence. The watchdog never starts before the hold delay has ended. Both run only in master mode. In slave mode chip select simply mirrors the shift engine's select request. All pins are plain control and status signals. No data flows through the block, so it has no valid/ready stream interface and applies no back-pressure.

Top module: `spi_eof_timer`

## Requirements
- R1: While `master_en` is low, `cs_n` equals the inverse of `frame_act`, `busy` is low from the next edge on, `last_bit` is ignored, and `desync` never becomes set.
- R2: In master mode, a `last_bit` pulse captured in the idle state keeps `cs_n` low for H edges, where H = `hold_cfg` + 1 with a minimum of 2. A field of 0 or 1 gives 2, and 255 gives 256. `cs_n` goes high on the H-th edge after the capturing edge.
- R3: With `hold_cfg` = 3, `cs_n` goes high exactly 4 clock cycles after the edge that captured `last_bit`.
- R4: The watchdog starts only after chip select has been released. It counts `sck_tick` pulses, not system-clock cycles, so its length scales with the tick rate.
- R5: If `ena_n` is sampled high in any cycle of the watchdog window, the watchdog stops, `desync` is not set, and `busy` falls two edges later.
- R6: If `ena_n` stays low until the `ena_tmo`-th tick of the window, `desync` is set on that tick's edge.
- R7: `desync` is sticky. It clears only on reset or on a `flag_clr` strobe. When a clear and an expiry fall on the same edge, the flag ends up set.
- R8: `busy` is high whenever the controller is not idle. A `last_bit` pulse that arrives while busy is ignored.
- R9: With `ena_tmo` = 0 the watchdog is skipped, and `busy` falls on the same edge that releases chip select.
- R10: Dropping `master_en` in any state returns the controller to idle on the next edge, and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | High selects master mode |
| frame_act | input | 1 | Shift engine requests chip select (character in flight) |
| last_bit | input | 1 | One-cycle pulse marking the end of the last bit |
| sck_tick | input | 1 | One-cycle pulse per SPI bit-clock period |
| hold_cfg | input | 8 | Chip-select hold field (hold = value + 1, minimum 2) |
| ena_tmo | input | 8 | Watchdog length in SPI ticks; 0 disables the watchdog |
| ena_n | input | 1 | Slave enable line, active low; high means acknowledge |
| flag_clr | input | 1 | One-cycle clear strobe for the flag |
| cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | Controller is not idle |
| desync | output | 1 | Sticky desynchronization flag |

## Verification
`busy` rises one edge after a captured `last_bit`. `cs_n` rises H edges after that capture. `desync` rises on the edge of the final watchdog tick. `busy` falls one edge after an acknowledge or an expiry, so two edges after the acknowledge is sampled. The bench drives inputs at the falling edge and advances its reference model at the rising edge. It compares `cs_n`, `busy` and `desync` two nanoseconds after every falling edge, so each result is checked in the exact cycle it is due. Directed checks measure the hold length in whole cycles, counting from the capturing edge to the edge where `cs_n` rises.

// File: rtl/eof_pkg.sv
package eof_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } eof_state_e;
endpackage

// File: rtl/eof_downcnt.sv
module eof_downcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= val;
    else if (dec && cnt != '0)   cnt <= cnt - 1'b1;
  end

  // terminal decrement: this step brings the count to zero
  assign last = dec && (cnt == W'(1));
endmodule

// File: rtl/eof_fsm.sv
module eof_fsm
  import eof_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       master_en,
  input  logic       last_bit,
  input  logic       sck_tick,
  input  logic       ena_ack,
  input  logic       tmo_off,
  input  logic       hold_last,
  input  logic       tmo_last,
  output eof_state_e state,
  output logic       hold_ld,
  output logic       hold_dec,
  output logic       tmo_ld,
  output logic       tmo_dec,
  output logic       expire
);
  eof_state_e nxt;

  always_comb begin
    nxt     = state;
    hold_ld = 1'b0;
    tmo_ld  = 1'b0;
    expire  = 1'b0;
    if (!master_en) begin
      nxt = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (last_bit) begin
          nxt     = ST_HOLD;
          hold_ld = 1'b1;
        end
        ST_HOLD: if (hold_last) begin
          if (tmo_off) nxt = ST_IDLE;
          else begin
            nxt    = ST_WAIT;
            tmo_ld = 1'b1;
          end
        end
        ST_WAIT: begin
          if (ena_ack) nxt = ST_DONE;
          else if (tmo_last) begin
            nxt    = ST_DONE;
            expire = 1'b1;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  assign hold_dec = (state == ST_HOLD);
  assign tmo_dec  = (state == ST_WAIT) && sck_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/eof_flag.sv
module eof_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/spi_eof_timer.sv
module spi_eof_timer
  import eof_pkg::*;
#(
  parameter int HOLD_W = 8,
  parameter int TMO_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_en,
  input  logic              frame_act,
  input  logic              last_bit,
  input  logic              sck_tick,
  input  logic [HOLD_W-1:0] hold_cfg,
  input  logic [TMO_W-1:0]  ena_tmo,
  input  logic              ena_n,
  input  logic              flag_clr,
  output logic              cs_n,
  output logic              busy,
  output logic              desync
);
  localparam int HCNT_W   = HOLD_W + 1;
  localparam int HOLD_MIN = 2;

  eof_state_e         state;
  logic               hold_ld, hold_dec, hold_last;
  logic               tmo_ld, tmo_dec, tmo_last;
  logic               expire;
  logic [HCNT_W-1:0]  hold_val;

  // hold = field + 1, never below the minimum
  assign hold_val = (HCNT_W'(hold_cfg) + HCNT_W'(1) < HCNT_W'(HOLD_MIN))
                    ? HCNT_W'(HOLD_MIN) : HCNT_W'(hold_cfg) + HCNT_W'(1);

  eof_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .master_en (master_en),
    .last_bit  (last_bit),
    .sck_tick  (sck_tick),
    .ena_ack   (ena_n),
    .tmo_off   (ena_tmo == '0),
    .hold_last (hold_last),
    .tmo_last  (tmo_last),
    .state     (state),
    .hold_ld   (hold_ld),
    .hold_dec  (hold_dec),
    .tmo_ld    (tmo_ld),
    .tmo_dec   (tmo_dec),
    .expire    (expire)
  );

  eof_downcnt #(.W(HCNT_W)) u_hold_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (hold_ld),
    .val   (hold_val),
    .dec   (hold_dec),
    .last  (hold_last)
  );

  eof_downcnt #(.W(TMO_W)) u_tmo_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmo_ld),
    .val   (ena_tmo),
    .dec   (tmo_dec),
    .last  (tmo_last)
  );

  eof_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (expire),
    .clr   (flag_clr),
    .flag  (desync)
  );

  assign busy = (state != ST_IDLE);
  assign cs_n = master_en ? !(frame_act || state == ST_HOLD) : !frame_act;
endmodule

// File: rtl/spi_eof_timer_chk.sv
module spi_eof_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic master_en,
  input logic frame_act,
  input logic ena_n,
  input logic sck_tick,
  input logic flag_clr,
  input logic cs_n,
  input logic busy,
  input logic desync
);
  AST_SLAVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> !busy); // R1

  AST_SLAVE_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_en && !desync) |=> !desync); // R1

  AST_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && master_en) |-> (!cs_n && busy) ##1 (!master_en || busy)); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (desync && !flag_clr) |=> desync); // R7

  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(desync) |-> ($past(busy) && !$past(ena_n) && $past(sck_tick) && $past(master_en))); // R6

  AST_ACK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(desync) |-> $past(cs_n)); // R4
endmodule

bind spi_eof_timer spi_eof_timer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .master_en (master_en),
  .frame_act (frame_act),
  .ena_n     (ena_n),
  .sck_tick  (sck_tick),
  .flag_clr  (flag_clr),
  .cs_n      (cs_n),
  .busy      (busy),
  .desync    (desync)
);

// File: tb/tb_spi_eof_timer.sv
`timescale 1ns/1ps
module tb_spi_eof_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       master_en = 1'b1;
  logic       frame_act = 1'b0;
  logic       last_bit = 1'b0;
  logic       sck_tick = 1'b0;
  logic [7:0] hold_cfg = 8'd0;
  logic [7:0] ena_tmo = 8'd0;
  logic       ena_n = 1'b0;
  logic       flag_clr = 1'b0;
  logic       cs_n, busy, desync;

  int n_vec = 0;
  int n_bad = 0;
  int tdiv  = 3;
  bit done  = 0;

  // reference model state
  int ph = 0;      // 0 idle, 1 hold, 2 watch, 3 finish
  int hleft = 0;
  int tleft = 0;
  bit mflag = 0;

  always #2.5 clk = ~clk;

  spi_eof_timer dut (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .frame_act(frame_act),
    .last_bit(last_bit), .sck_tick(sck_tick), .hold_cfg(hold_cfg),
    .ena_tmo(ena_tmo), .ena_n(ena_n), .flag_clr(flag_clr),
    .cs_n(cs_n), .busy(busy), .desync(desync)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; mflag = 0;
    end else begin
      bit fire;
      fire = 0;
      if (!master_en) ph = 0;                        // R1 R10
      else if (ph == 0) begin
        if (last_bit) begin
          ph = 1;
          hleft = (hold_cfg < 1) ? 2 : hold_cfg + 1;  // R2
        end
      end else if (ph == 1) begin
        hleft = hleft - 1;
        if (hleft == 0) begin
          if (ena_tmo == 0) ph = 0;                  // R9
          else begin ph = 2; tleft = ena_tmo; end    // R4
        end
      end else if (ph == 2) begin
        if (ena_n) ph = 3;                           // R5
        else if (sck_tick) begin
          tleft = tleft - 1;
          if (tleft == 0) begin fire = 1; ph = 3; end // R6
        end
      end else ph = 0;
      if (fire) mflag = 1;                           // R7
      else if (flag_clr) mflag = 0;
    end
  end

  task automatic check(input bit act, input bit exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      check(cs_n, master_en ? !(frame_act || ph == 1) : !frame_act, "R1 R2 R3 cs_n");
      check(busy, ph != 0, "R5 R8 R9 R10 busy");
      check(desync, mflag, "R4 R6 R7 desync");
    end
  end

  // SPI tick source
  initial begin
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      c++;
      if (c >= tdiv) begin c = 0; sck_tick = 1'b1; end
      else sck_tick = 1'b0;
    end
  end

  task automatic start_frame(input int hold, input int tmo);
    hold_cfg = 8'(hold); ena_tmo = 8'(tmo);
    frame_act = 1'b1;
    repeat (2) @(negedge clk);
    last_bit = 1'b1;
    @(negedge clk);
    last_bit = 1'b0; frame_act = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk); #1;
    while (busy) begin @(negedge clk); #1; end
    @(negedge clk);
  endtask

  task automatic measure_hold(input int field, input int exp, input string tag);
    int n;
    hold_cfg = 8'(field); ena_tmo = 8'd0;
    frame_act = 1'b1;
    repeat (2) @(negedge clk);
    last_bit = 1'b1;
    @(negedge clk);
    last_bit = 1'b0; frame_act = 1'b0;
    n = 1; #1;
    while (!cs_n && n < 400) begin @(negedge clk); #1; n++; end
    check(1'b1, (n - 1) == exp, tag);
    if ((n - 1) != exp) $display("FAIL %s hold actual=%0d expected=%0d", tag, n - 1, exp);
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(cs_n, 1'b1, "reset cs_n");
    check(busy, 1'b0, "reset busy");
    check(desync, 1'b0, "reset desync");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: field 3 gives exactly four cycles
    measure_hold(3, 4, "R3 hold=4");
    // R2: clamp and full range
    measure_hold(0, 2, "R2 field0");
    measure_hold(1, 2, "R2 field1");
    measure_hold(255, 256, "R2 field255");

    // R6 R4: expiry with slow and fast ticks
    tdiv = 4;
    start_frame(2, 3);
    wait_idle();
    check(desync, 1'b1, "R6 expiry sets flag");
    // R7: clear strobe
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0; #1;
    check(desync, 1'b0, "R7 clear");
    tdiv = 1;
    start_frame(5, 6);
    wait_idle();
    check(desync, 1'b1, "R4 tick-rate expiry");

    // R7: clear held through expiry, set wins on the shared edge
    flag_clr = 1'b1;
    @(negedge clk);
    tdiv = 2;
    start_frame(1, 2);
    begin
      bit seen;
      seen = 0;
      repeat (40) begin @(negedge clk); #1; if (desync) seen = 1; end
      check(seen, 1'b1, "R7 set beats clear");
    end
    flag_clr = 1'b0;
    wait_idle();

    // R5: acknowledge inside the window
    tdiv = 5;
    start_frame(2, 20);
    repeat (8) @(negedge clk);
    ena_n = 1'b1;
    wait_idle();
    ena_n = 1'b0;
    check(desync, 1'b0, "R5 ack no flag");

    // R8: second last_bit while busy ignored
    start_frame(10, 0);
    repeat (3) @(negedge clk);
    last_bit = 1'b1; @(negedge clk); last_bit = 1'b0;
    wait_idle();

    // R9: watchdog off
    start_frame(4, 0);
    wait_idle();
    check(desync, 1'b0, "R9 no watchdog");

    // R10: abort mid-window
    tdiv = 3;
    start_frame(2, 50);
    repeat (6) @(negedge clk);
    master_en = 1'b0;
    @(negedge clk); #1;
    check(busy, 1'b0, "R10 abort");
    // R1: slave mode
    frame_act = 1'b1; last_bit = 1'b1;
    @(negedge clk);
    last_bit = 1'b0;
    repeat (4) @(negedge clk);
    frame_act = 1'b0;
    repeat (4) @(negedge clk); #1;
    check(busy, 1'b0, "R1 slave idle");
    check(desync, 1'b0, "R1 slave no flag");
    master_en = 1'b1;
    repeat (4) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule